// File: doc/BRIEF.md
# Cache Flush Command Sequencer

This block takes cache maintenance commands as 32-bit words written through two register strobes. It then walks the tag, valid and dirty state of a 4-way set-associative cache, one line per step. It can invalidate lines, write dirty lines back to memory, or overwrite a whole way with a tag and valid/dirty state chosen by software. When a way is overwritten, it can also fetch each line from memory.

The first command format selects lines by memory address: either the one line whose tag matches, or every line in the cache. The second format selects lines by set and way: either one line, or a way operation that touches every set of one way. Write-backs and fills leave through two valid/ready request ports, each carrying a line address. A sticky cache-off output is loaded from a disable bit that both formats carry. The line state is held inside the block. A load port stands in for the normal allocation path and a probe port stands in for the lookup path.

Top module: `cflush_seq`

## Requirements
- R1: Address format (`cmd_addr_we`). The mode is bits 2:0 and the address is bits 31:5. The set is taken from bits 10:5 and the tag from bits 31:11. With bit 2 clear, mode 001 invalidates, 010 writes back, and 011 writes back and then invalidates. These act only on valid lines of that set whose tag matches. Every other line is left unchanged.
- R2: Address format modes 101, 110 and 111 apply the same three operations to every line. The address field is ignored.
- R3: A write-back request is raised only for a line that is both valid and dirty. Its address is {stored tag, set, 5'b0}. A clean line is never written back.
- R4: A write-back request holds `wb_valid` and `wb_addr` until `wb_ready`. The line's dirty bit is cleared, or the line is invalidated, only in the cycle of acceptance.
- R5: Bit 3 of any accepted command word, in either format, is loaded into `cache_off`. Otherwise `cache_off` keeps its value.
- R6: Set/index format (`cmd_idx_we`) with bit 2 clear selects one line. The set is taken from bits 16+ and the way from bits 5:4. Mode 01 invalidates the line, 10 writes it back if dirty, and 11 writes it back if dirty and then invalidates it.
- R7: Set/index format with bit 2 set and mode 01 loads every line of the selected way. The tag comes from bits 31:11, valid from bit 8 and dirty from bit 7. Nothing is written back.
- R8: With bit 2 set, mode 10 writes back the dirty lines of the selected way and leaves them valid and clean. Mode 11 writes back each dirty line first and then loads the supplied tag, valid and dirty bits.
- R9: During a way load, bit 9 set requests a fill for every line of the way at {new tag, set, 5'b0}. Each fill request is held until `fill_ready`. At most one request port is active at a time.
- R10: A multi-line operation visits sets in ascending order. Within a set it visits ways in ascending order.
- R11: `busy` is high from the cycle after an accepted command until its last line is done. Commands written while busy are ignored, disable bit included. An operation field of 00 starts no walk and leaves `busy` low.
- R12: After reset all lines are invalid and clean. `busy`, `cache_off`, `wb_valid` and `fill_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_addr_we | input | 1 | Write strobe, address-format command |
| cmd_idx_we | input | 1 | Write strobe, set/index-format command |
| cmd_wdata | input | 32 | Command word |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request accepted |
| wb_addr | output | 32 | Write-back line address |
| fill_valid | output | 1 | Fill request valid |
| fill_ready | input | 1 | Fill request accepted |
| fill_addr | output | 32 | Fill line address |
| cache_off | output | 1 | Cache disabled by the last accepted command |
| busy | output | 1 | Walk in progress |
| ld_we | input | 1 | Line load strobe (allocation path) |
| ld_set | input | 6 | Set of the line to load |
| ld_way | input | 2 | Way of the line to load |
| ld_tag | input | 21 | Tag to load |
| ld_valid | input | 1 | Valid bit to load |
| ld_dirty | input | 1 | Dirty bit to load |
| probe_set | input | 6 | Set of the line to observe |
| probe_way | input | 2 | Way of the line to observe |
| probe_tag | output | 21 | Observed tag |
| probe_valid | output | 1 | Observed valid bit |
| probe_dirty | output | 1 | Observed dirty bit |

## Verification
The hardest situation to reach is the window between raising a write-back and its acceptance. In that window the line must still look dirty and the request must not move. The memory stub therefore has an adjustable acceptance latency. It is stretched for one test while the probe port reads the line mid-wait. A second hard case is a command written while a way walk is running, to show that the command is dropped. The bench fires that command in the cycle after the walk begins. It then checks both the line it targets and `cache_off` once the walk ends. Visit order is checked by seeding dirty lines out of order across sets and ways, then comparing the logged write-back sequence.

// File: rtl/cflush_pkg.sv
package cflush_pkg;

    localparam int unsigned CMD_W      = 32;
    localparam int unsigned LINE_OFS_W = 5;
    localparam int unsigned NUM_WAYS   = 4;
    localparam int unsigned WAY_W      = $clog2(NUM_WAYS);

    // Command word bit positions shared by both formats / by the set-index format
    localparam int unsigned B_DIS      = 3;
    localparam int unsigned B_WAYOP    = 2;
    localparam int unsigned B_FETCH    = 9;
    localparam int unsigned B_NEWV     = 8;
    localparam int unsigned B_NEWD     = 7;
    localparam int unsigned B_WAY_LO   = 4;
    localparam int unsigned B_SET_LO   = 16;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_VISIT,
        WS_WB,
        WS_FILL
    } walk_state_e;

    typedef struct packed {
        logic             go;        // a walk is needed
        logic             all_sets;  // sweep every set
        logic             one_way;   // stay on the selected way
        logic             match;     // act only on tag hits
        logic             do_wb;
        logic             do_inv;
        logic             do_load;
        logic             fetch;
        logic             new_v;
        logic             new_d;
        logic [WAY_W-1:0] way;
    } flush_op_t;

endpackage

// File: rtl/cflush_decode.sv
module cflush_decode
    import cflush_pkg::*;
#(
    parameter int unsigned SET_W = 6,
    parameter int unsigned TAG_W = 21
) (
    input  logic             addr_fmt,
    input  logic [CMD_W-1:0] wdata,
    output flush_op_t        op,
    output logic [SET_W-1:0] set,
    output logic [TAG_W-1:0] tag,
    output logic             dis
);

    always_comb begin
        op  = '0;
        dis = wdata[B_DIS];
        tag = wdata[CMD_W-1 -: TAG_W];
        if (addr_fmt) begin
            set         = wdata[LINE_OFS_W +: SET_W];
            op.go       = |wdata[1:0];
            op.do_inv   = wdata[0];
            op.do_wb    = wdata[1];
            op.all_sets = wdata[2];
            op.match    = ~wdata[2];
        end else begin
            set         = wdata[B_SET_LO +: SET_W];
            op.go       = |wdata[1:0];
            op.one_way  = 1'b1;
            op.way      = wdata[B_WAY_LO +: WAY_W];
            op.all_sets = wdata[B_WAYOP];
            op.do_wb    = wdata[1];
            op.do_inv   = ~wdata[B_WAYOP] & wdata[0];
            op.do_load  = wdata[B_WAYOP] & wdata[0];
            op.fetch    = wdata[B_WAYOP] & wdata[B_FETCH];
            op.new_v    = wdata[B_NEWV];
            op.new_d    = wdata[B_NEWD];
        end
    end

endmodule

// File: rtl/cflush_lines.sv
module cflush_lines
    import cflush_pkg::*;
#(
    parameter int unsigned LINE_W = 8,
    parameter int unsigned TAG_W  = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_v,
    output logic              rd_d,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_v,
    input  logic              wr_d,
    input  logic              ld_en,
    input  logic [LINE_W-1:0] ld_idx,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic              ld_v,
    input  logic              ld_d,
    input  logic [LINE_W-1:0] pr_idx,
    output logic [TAG_W-1:0]  pr_tag,
    output logic              pr_v,
    output logic              pr_d
);

    localparam int unsigned LINES = 1 << LINE_W;

    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    logic              we;
    logic [LINE_W-1:0] widx;
    logic [TAG_W-1:0]  wtag;
    logic              wv;
    logic              wd;

    // The sequencer's write wins over the allocation path
    always_comb begin
        we   = wr_en | ld_en;
        widx = wr_en ? wr_idx : ld_idx;
        wtag = wr_en ? wr_tag : ld_tag;
        wv   = wr_en ? wr_v   : ld_v;
        wd   = wr_en ? wr_d   : ld_d;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_mem[widx] <= wtag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (we) begin
            valid_q[widx] <= wv;
            dirty_q[widx] <= wd;
        end
    end

    assign rd_tag = tag_mem[rd_idx];
    assign rd_v   = valid_q[rd_idx];
    assign rd_d   = dirty_q[rd_idx];
    assign pr_tag = tag_mem[pr_idx];
    assign pr_v   = valid_q[pr_idx];
    assign pr_d   = dirty_q[pr_idx];

endmodule

// File: rtl/cflush_seq.sv
module cflush_seq
    import cflush_pkg::*;
#(
    parameter int unsigned NUM_SETS = 64
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         cmd_addr_we,
    input  logic                                         cmd_idx_we,
    input  logic [CMD_W-1:0]                             cmd_wdata,
    output logic                                         wb_valid,
    input  logic                                         wb_ready,
    output logic [CMD_W-1:0]                             wb_addr,
    output logic                                         fill_valid,
    input  logic                                         fill_ready,
    output logic [CMD_W-1:0]                             fill_addr,
    output logic                                         cache_off,
    output logic                                         busy,
    input  logic                                         ld_we,
    input  logic [$clog2(NUM_SETS)-1:0]                  ld_set,
    input  logic [WAY_W-1:0]                             ld_way,
    input  logic [CMD_W-$clog2(NUM_SETS)-LINE_OFS_W-1:0] ld_tag,
    input  logic                                         ld_valid,
    input  logic                                         ld_dirty,
    input  logic [$clog2(NUM_SETS)-1:0]                  probe_set,
    input  logic [WAY_W-1:0]                             probe_way,
    output logic [CMD_W-$clog2(NUM_SETS)-LINE_OFS_W-1:0] probe_tag,
    output logic                                         probe_valid,
    output logic                                         probe_dirty
);

    localparam int unsigned SET_W  = $clog2(NUM_SETS);
    localparam int unsigned TAG_W  = CMD_W - SET_W - LINE_OFS_W;
    localparam int unsigned LINE_W = SET_W + WAY_W;
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(NUM_SETS - 1);
    localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(NUM_WAYS - 1);
    localparam logic [LINE_OFS_W-1:0] OFS_ZERO = '0;

    walk_state_e      st_q, st_d;
    flush_op_t        op_q, dec_op;
    logic [TAG_W-1:0] ctag_q, dec_tag;
    logic [SET_W-1:0] set_q, set_d, dec_set;
    logic [WAY_W-1:0] way_q, way_d;
    logic [CMD_W-1:0] req_q, req_d;
    logic             off_q, dec_dis;

    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic             rd_v, rd_d, wr_en, wr_v, wr_d;
    logic             cmd_take, hit, need_wb, go_fill, step, last_line;

    cflush_decode #(.SET_W(SET_W), .TAG_W(TAG_W)) dec_i (
        .addr_fmt (cmd_addr_we),
        .wdata    (cmd_wdata),
        .op       (dec_op),
        .set      (dec_set),
        .tag      (dec_tag),
        .dis      (dec_dis)
    );

    cflush_lines #(.LINE_W(LINE_W), .TAG_W(TAG_W)) lines_i (
        .clk    (clk),
        .rst    (rst),
        .rd_idx ({set_q, way_q}),
        .rd_tag (rd_tag),
        .rd_v   (rd_v),
        .rd_d   (rd_d),
        .wr_en  (wr_en),
        .wr_idx ({set_q, way_q}),
        .wr_tag (wr_tag),
        .wr_v   (wr_v),
        .wr_d   (wr_d),
        .ld_en  (ld_we),
        .ld_idx ({ld_set, ld_way}),
        .ld_tag (ld_tag),
        .ld_v   (ld_valid),
        .ld_d   (ld_dirty),
        .pr_idx ({probe_set, probe_way}),
        .pr_tag (probe_tag),
        .pr_v   (probe_valid),
        .pr_d   (probe_dirty)
    );

    // Per-line decision for the line under the walk pointer
    always_comb begin
        cmd_take  = (cmd_addr_we | cmd_idx_we) && (st_q == WS_IDLE);
        hit       = ~op_q.match | (rd_v && (rd_tag == ctag_q));
        need_wb   = hit & op_q.do_wb & rd_v & rd_d;
        go_fill   = hit & op_q.do_load & op_q.fetch;
        last_line = (~op_q.all_sets | (set_q == SET_LAST)) &
                    (op_q.one_way | (way_q == WAY_LAST));
        wr_en     = ((st_q == WS_WB) && wb_ready) ||
                    ((st_q == WS_VISIT) && hit && !need_wb && (op_q.do_inv || op_q.do_load));
        wr_tag    = op_q.do_load ? ctag_q : rd_tag;
        wr_v      = op_q.do_load ? op_q.new_v : (op_q.do_inv ? 1'b0 : rd_v);
        wr_d      = op_q.do_load & op_q.new_d;
    end

    // Next-state and walk pointer
    always_comb begin
        st_d  = st_q;
        set_d = set_q;
        way_d = way_q;
        req_d = req_q;
        step  = 1'b0;
        unique case (st_q)
            WS_IDLE: begin
                if (cmd_take && dec_op.go) begin
                    st_d  = WS_VISIT;
                    set_d = dec_op.all_sets ? '0 : dec_set;
                    way_d = dec_op.one_way ? dec_op.way : '0;
                end
            end
            WS_VISIT: begin
                if (need_wb) begin
                    req_d = {rd_tag, set_q, OFS_ZERO};
                    st_d  = WS_WB;
                end else if (go_fill) begin
                    req_d = {ctag_q, set_q, OFS_ZERO};
                    st_d  = WS_FILL;
                end else begin
                    step = 1'b1;
                end
            end
            WS_WB: begin
                if (wb_ready) begin
                    if (go_fill) begin
                        req_d = {ctag_q, set_q, OFS_ZERO};
                        st_d  = WS_FILL;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            WS_FILL: begin
                step = fill_ready;
            end
        endcase
        if (step) begin
            if (last_line) begin
                st_d = WS_IDLE;
            end else begin
                st_d = WS_VISIT;
                if (op_q.one_way || (way_q == WAY_LAST)) begin
                    way_d = op_q.one_way ? way_q : '0;
                    set_d = set_q + SET_W'(1);
                end else begin
                    way_d = way_q + WAY_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WS_IDLE;
            op_q   <= '0;
            ctag_q <= '0;
            set_q  <= '0;
            way_q  <= '0;
            req_q  <= '0;
            off_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            set_q <= set_d;
            way_q <= way_d;
            req_q <= req_d;
            if (cmd_take) begin
                off_q <= dec_dis;
                if (dec_op.go) begin
                    op_q   <= dec_op;
                    ctag_q <= dec_tag;
                end
            end
        end
    end

    assign wb_valid   = (st_q == WS_WB);
    assign fill_valid = (st_q == WS_FILL);
    assign wb_addr    = req_q;
    assign fill_addr  = req_q;
    assign cache_off  = off_q;
    assign busy       = (st_q != WS_IDLE);

endmodule

// File: rtl/cflush_seq_chk.sv
module cflush_seq_chk
    import cflush_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_addr_we,
    input logic             cmd_idx_we,
    input logic [CMD_W-1:0] cmd_wdata,
    input logic             wb_valid,
    input logic             wb_ready,
    input logic [CMD_W-1:0] wb_addr,
    input logic             fill_valid,
    input logic             fill_ready,
    input logic [CMD_W-1:0] fill_addr,
    input logic             cache_off,
    input logic             busy
);

    p_wb_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr)));

    p_fill_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_addr)));

    p_one_port_r9: assert property (@(posedge clk) disable iff (rst)
        !(wb_valid && fill_valid));

    p_req_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (wb_valid || fill_valid) |-> busy);

    p_off_load_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && (cmd_addr_we || cmd_idx_we)) |=> (cache_off == $past(cmd_wdata[B_DIS])));

    p_off_keep_r11: assert property (@(posedge clk) disable iff (rst)
        !(!busy && (cmd_addr_we || cmd_idx_we)) |=> $stable(cache_off));

endmodule

bind cflush_seq cflush_seq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_addr_we (cmd_addr_we),
    .cmd_idx_we  (cmd_idx_we),
    .cmd_wdata   (cmd_wdata),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_addr     (wb_addr),
    .fill_valid  (fill_valid),
    .fill_ready  (fill_ready),
    .fill_addr   (fill_addr),
    .cache_off   (cache_off),
    .busy        (busy)
);

// File: tb/cflush_seq_tb_top.sv
module cflush_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic        is_idx;
        logic [31:0] wd;
        logic        pre_d;
        logic [1:0]  nwb;
        logic        ev;
        logic        ed;
        logic [20:0] etag;
    } vec_t;

    // Preloaded line: set 5, way 2, tag 0x1234, valid -> address 0x0091A0A0
    localparam logic [5:0]  T_SET  = 6'd5;
    localparam logic [1:0]  T_WAY  = 2'd2;
    localparam logic [20:0] T_TAG  = 21'h1234;
    localparam logic [31:0] T_ADDR = 32'h0091A0A0;
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0091A0A1, 1'b1, 2'd0, 1'b0, 1'b0, 21'h1234},  // R1 inv hit
        '{1'b0, 32'h0091A0A2, 1'b1, 2'd1, 1'b1, 1'b0, 21'h1234},  // R1 wb hit
        '{1'b0, 32'h0091A0A3, 1'b1, 2'd1, 1'b0, 1'b0, 21'h1234},  // R1 wb+inv
        '{1'b0, 32'h0091A8A2, 1'b1, 2'd0, 1'b1, 1'b1, 21'h1234},  // R1 tag miss
        '{1'b0, 32'h0091A0A2, 1'b0, 2'd0, 1'b1, 1'b0, 21'h1234},  // R3 clean
        '{1'b0, 32'h12345676, 1'b1, 2'd1, 1'b1, 1'b0, 21'h1234},  // R2 all wb, junk addr
        '{1'b0, 32'h00000007, 1'b1, 2'd1, 1'b0, 1'b0, 21'h1234},  // R2 all wb+inv
        '{1'b1, 32'h00050021, 1'b1, 2'd0, 1'b0, 1'b0, 21'h1234},  // R6 inv
        '{1'b1, 32'h00050022, 1'b1, 2'd1, 1'b1, 1'b0, 21'h1234},  // R6 wb
        '{1'b1, 32'h00050023, 1'b1, 2'd1, 1'b0, 1'b0, 21'h1234},  // R6 wb+inv
        '{1'b1, 32'h00050011, 1'b1, 2'd0, 1'b1, 1'b1, 21'h1234},  // R6 other way
        '{1'b1, 32'h055E6925, 1'b1, 2'd0, 1'b1, 1'b0, 21'h0ABCD}, // R7 way load
        '{1'b1, 32'h00000026, 1'b1, 2'd1, 1'b1, 1'b0, 21'h1234},  // R8 way wb
        '{1'b1, 32'h055E68A7, 1'b1, 2'd1, 1'b0, 1'b1, 21'h0ABCD}  // R8 way wb+load
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_addr_we = 1'b0, cmd_idx_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        wb_valid, fill_valid, cache_off, busy;
    logic        wb_ready = 1'b0, fill_ready = 1'b0;
    logic [31:0] wb_addr, fill_addr;
    logic        ld_we = 1'b0, ld_valid = 1'b0, ld_dirty = 1'b0;
    logic [5:0]  ld_set = '0, probe_set = '0;
    logic [1:0]  ld_way = '0, probe_way = '0;
    logic [20:0] ld_tag = '0, probe_tag;
    logic        probe_valid, probe_dirty;

    int n_chk = 0, n_fail = 0, cycles = 0;
    int wb_n = 0, fill_n = 0, wb_cnt = 0, fill_cnt = 0;
    int wb_lat = 1;
    logic [31:0] wb_log [1024];
    logic [31:0] fill_log [1024];

    cflush_seq dut_i (
        .clk(clk), .rst(rst), .cmd_addr_we(cmd_addr_we), .cmd_idx_we(cmd_idx_we),
        .cmd_wdata(cmd_wdata), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
        .cache_off(cache_off), .busy(busy), .ld_we(ld_we), .ld_set(ld_set), .ld_way(ld_way),
        .ld_tag(ld_tag), .ld_valid(ld_valid), .ld_dirty(ld_dirty), .probe_set(probe_set),
        .probe_way(probe_way), .probe_tag(probe_tag), .probe_valid(probe_valid),
        .probe_dirty(probe_dirty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // Memory stub: accepts each request after a latency, logging addresses
    always @(negedge clk) begin
        if (wb_valid) begin
            if (wb_cnt >= wb_lat) begin
                wb_ready = 1'b1;
                wb_log[wb_n % 1024] = wb_addr;
                wb_n++;
                wb_cnt = 0;
            end else begin
                wb_ready = 1'b0;
                wb_cnt++;
            end
        end else begin
            wb_ready = 1'b0;
            wb_cnt = 0;
        end
        if (fill_valid) begin
            if (fill_cnt >= 1) begin
                fill_ready = 1'b1;
                fill_log[fill_n % 1024] = fill_addr;
                fill_n++;
                fill_cnt = 0;
            end else begin
                fill_ready = 1'b0;
                fill_cnt++;
            end
        end else begin
            fill_ready = 1'b0;
            fill_cnt = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic is_idx, input logic [31:0] wd);
        @(negedge clk);
        cmd_wdata   = wd;
        cmd_addr_we = ~is_idx;
        cmd_idx_we  = is_idx;
        @(negedge clk);
        cmd_addr_we = 1'b0;
        cmd_idx_we  = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        if (busy) chk("R11 walk ends", 32'(busy), 32'd0);
    endtask

    task automatic run(input logic is_idx, input logic [31:0] wd);
        issue(is_idx, wd);
        wait_idle();
    endtask

    task automatic preload(input logic [5:0] s, input logic [1:0] w, input logic [20:0] t,
                           input logic v, input logic d);
        @(negedge clk);
        ld_we = 1'b1; ld_set = s; ld_way = w; ld_tag = t; ld_valid = v; ld_dirty = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic probe(input logic [5:0] s, input logic [1:0] w);
        probe_set = s;
        probe_way = w;
        #1;
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        probe(T_SET, T_WAY);
        chk("R12 busy", 32'(busy), 32'd0);
        chk("R12 cache_off", 32'(cache_off), 32'd0);
        chk("R12 req idle", {30'd0, wb_valid, fill_valid}, 32'd0);
        chk("R12 line state", {30'd0, probe_valid, probe_dirty}, 32'd0);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            run(1'b0, 32'h00000005);
            preload(T_SET, T_WAY, T_TAG, 1'b1, VECS[k].pre_d);
            base = wb_n;
            run(VECS[k].is_idx, VECS[k].wd);
            probe(T_SET, T_WAY);
            chk($sformatf("vec%0d wb count", k), 32'(wb_n - base), 32'(VECS[k].nwb));
            if (VECS[k].nwb != 0)
                chk($sformatf("R3 vec%0d wb addr", k), wb_log[base % 1024], T_ADDR);
            chk($sformatf("vec%0d valid/dirty", k), {30'd0, probe_valid, probe_dirty},
                {30'd0, VECS[k].ev, VECS[k].ed});
            if (VECS[k].ev)
                chk($sformatf("vec%0d tag", k), 32'(probe_tag), 32'(VECS[k].etag));
        end

        // R4: line stays dirty and request stays put until accepted
        run(1'b0, 32'h00000005);
        preload(T_SET, T_WAY, T_TAG, 1'b1, 1'b1);
        wb_lat = 6;
        issue(1'b1, 32'h00050022);
        for (int i = 0; i < 20 && !wb_valid; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        probe(T_SET, T_WAY);
        chk("R4 still dirty while waiting", {30'd0, probe_valid, probe_dirty}, 32'd3);
        chk("R4 request held", {31'd0, wb_valid}, 32'd1);
        chk("R4 addr held", wb_addr, T_ADDR);
        wait_idle();
        wb_lat = 1;
        probe(T_SET, T_WAY);
        chk("R4 clean after accept", {30'd0, probe_valid, probe_dirty}, 32'd2);

        // R5 and R11: op field 00 only touches cache_off
        issue(1'b0, 32'h00000008);
        chk("R11 no walk on op 00", 32'(busy), 32'd0);
        chk("R5 off from address format", 32'(cache_off), 32'd1);
        issue(1'b1, 32'h00000000);
        chk("R5 off cleared", 32'(cache_off), 32'd0);
        issue(1'b1, 32'h00000008);
        chk("R5 off from set/index format", 32'(cache_off), 32'd1);

        // R11: command during a way walk is ignored
        run(1'b0, 32'h00000005);
        preload(T_SET, T_WAY, T_TAG, 1'b1, 1'b1);
        issue(1'b1, 32'h00000026);
        chk("R11 busy during walk", 32'(busy), 32'd1);
        issue(1'b1, 32'h00050029);
        wait_idle();
        probe(T_SET, T_WAY);
        chk("R11 ignored command", {30'd0, probe_valid, probe_dirty}, 32'd2);
        chk("R11 ignored disable", 32'(cache_off), 32'd0);

        // R10: visit order
        run(1'b0, 32'h00000005);
        preload(6'd9, 2'd0, 21'd7, 1'b1, 1'b1);
        preload(6'd3, 2'd3, 21'd8, 1'b1, 1'b1);
        preload(6'd3, 2'd1, 21'd9, 1'b1, 1'b1);
        base = wb_n;
        run(1'b0, 32'h00000006);
        chk("R10 wb count", 32'(wb_n - base), 32'd3);
        chk("R10 first", wb_log[base % 1024], 32'h00004860);
        chk("R10 second", wb_log[(base + 1) % 1024], 32'h00004060);
        chk("R10 third", wb_log[(base + 2) % 1024], 32'h00003920);

        // R9: way load with fetch
        base = fill_n;
        run(1'b1, 32'h00011315);
        chk("R9 fill count", 32'(fill_n - base), 32'd64);
        chk("R9 fill set0", fill_log[base % 1024], 32'h00011000);
        chk("R9 fill set1", fill_log[(base + 1) % 1024], 32'h00011020);
        probe(6'd63, 2'd1);
        chk("R9 line loaded", {probe_valid, probe_dirty, 9'd0, probe_tag}, {2'b10, 9'd0, 21'h22});

        finish_run();
    end

endmodule